// File: doc/BRIEF.md
# Flash High-Voltage Program/Erase Sequencer

This block drives the four high-voltage control lines of an embedded flash array (erase, whole-array select, program and high-voltage enable) through a fixed order, holding each phase for a minimum dwell. Every dwell is set in microseconds and turned into clock cycles by a cycles-per-microsecond parameter. Two commands are accepted: erase of the whole array and programming of one aligned row.

For a row program the sequencer presents the address of the next target byte. The array returns that byte's current content, and the data bytes arrive one at a time over a valid/ready handshake. Each accepted blank byte is issued as a one-cycle write strobe. Protected arrays, misaligned rows, non-blank targets and stalled byte streams are refused or aborted. An abort still takes the normal release path: mode lines off first, then high voltage after a hold, then a recovery dwell. Busy, a done pulse and an error pulse with a two-bit cause report the outcome.

Top module: `flash_hv_sequencer`

## Requirements
- R1: After reset all four high-voltage lines, busy, done, err, wr_ready and prog_we are low.
- R2: A mass erase (cmd_op=1) raises hv_erase and hv_mass together. hv_en rises exactly T_NVS_US*CYC_PER_US cycles later. Both mode lines fall exactly T_MERASE_US*CYC_PER_US cycles after hv_en rose.
- R3: hv_en falls exactly T_NVHL_US*CYC_PER_US cycles after the mode lines fall, on success and on every abort. hv_en never rises without a mode line high, never falls while one is high, and no mode line rises while hv_en is high.
- R4: busy stays high for T_RCV_US*CYC_PER_US cycles after hv_en falls. The end pulse (done or err) comes in the first cycle with busy low.
- R5: A mass erase with protect_val other than 8'hFF gives an err pulse with err_code 0 in the cycle after the command. busy stays low and no high-voltage line moves.
- R6: A row program (cmd_op=0) whose cmd_addr has any of its low log2(ROW_BYTES) bits set gives an err pulse with err_code 1 in the next cycle. No line moves.
- R7: A row program raises hv_pgm, then hv_en exactly T_NVS_US*CYC_PER_US cycles later, then wr_ready exactly T_PGS_US*CYC_PER_US cycles after hv_en.
- R8: Each byte accepted (wr_valid and wr_ready) is written to row base plus its index, with prog_we high in the cycle after acceptance. hv_pgm falls in the cycle after the ROW_BYTES-th acceptance.
- R9: An accepted byte whose current content (chk_data) is not 8'hFF is not written. hv_pgm falls in the next cycle, and the sequence ends with an err pulse with err_code 2.
- R10: If no byte is accepted in T_PROG_MAX_US*CYC_PER_US consecutive cycles after wr_ready rises or after the last acceptance, hv_pgm falls in the next cycle and the sequence ends with err_code 3. A gap one cycle shorter does not abort.
- R11: A command presented while busy is high is ignored.
- R12: done and err are one-cycle pulses and never coincide. An aborted sequence ends with err, not done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 1 | 1 = mass erase, 0 = row program |
| cmd_addr | input | ADDR_W | Row start address (any in-array address for erase) |
| protect_val | input | 8 | Block-protect value; 8'hFF means unprotected |
| wr_valid | input | 1 | Program data byte offered |
| wr_data | input | 8 | Program data byte |
| wr_ready | output | 1 | Byte can be accepted this cycle |
| chk_addr | output | ADDR_W | Address of the next target byte |
| chk_data | input | 8 | Current array content at chk_addr |
| prog_we | output | 1 | Byte write strobe to the array |
| prog_addr | output | ADDR_W | Write address |
| prog_data | output | 8 | Write data |
| hv_erase | output | 1 | Erase mode line |
| hv_mass | output | 1 | Whole-array select line |
| hv_pgm | output | 1 | Program mode line |
| hv_en | output | 1 | High-voltage enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Refusal or abort pulse |
| err_code | output | 2 | Cause with err: 0 protect, 1 alignment, 2 not blank, 3 timeout |

## Verification
A wrong internal state shows at the ports as a line edge in the wrong cycle. Every dwell is checked as an exact cycle difference between edges, so an off-by-one in the shared counter or a wrong reload value shows on the very next line edge. A wrong ordering, such as high voltage dropping while a mode line is still on, appears in the cycle it happens. A broken row counter or blank check shows at the array port: as a write to the wrong address, or as a write to a non-blank byte, one cycle after acceptance. A broken stall watchdog shows as a release of hv_pgm in the wrong cycle relative to the last acceptance.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HV_ERASE,
    ST_HV_PGS,
    ST_PROG,
    ST_HOLD,
    ST_RECOVER
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_PROTECT = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_BLANK   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } seq_err_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fhs_dwell_timer.sv
module fhs_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fhs_cmd_screen.sv
module fhs_cmd_screen
  import fhs_pkg::*;
#(
  parameter int ROW_LSB = 5
) (
  input  logic               is_erase,
  input  logic [ROW_LSB-1:0] row_offset,
  input  logic [7:0]         protect_val,
  output logic               reject,
  output seq_err_t           reject_code
);

  always_comb begin
    reject      = 1'b0;
    reject_code = ERR_PROTECT;
    if (is_erase) begin
      if (protect_val != 8'hFF) begin
        reject      = 1'b1;
        reject_code = ERR_PROTECT;
      end
    end else if (row_offset != '0) begin
      reject      = 1'b1;
      reject_code = ERR_ALIGN;
    end
  end

endmodule

// File: rtl/fhs_row_tracker.sv
module fhs_row_tracker #(
  parameter int ADDR_W  = 8,
  parameter int ROW_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (start) begin
      addr_q <= base;
    end else if (advance) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign cur_addr = addr_q;
  assign at_last  = &addr_q[ROW_LSB-1:0];

endmodule

// File: rtl/flash_hv_sequencer.sv
module flash_hv_sequencer
  import fhs_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int ROW_BYTES     = 32,
  parameter int CYC_PER_US    = 8,
  parameter int T_NVS_US      = 10,
  parameter int T_PGS_US      = 5,
  parameter int T_MERASE_US   = 4000,
  parameter int T_NVHL_US     = 100,
  parameter int T_RCV_US      = 1,
  parameter int T_PROG_MAX_US = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        protect_val,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic [7:0]        chk_data,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              hv_erase,
  output logic              hv_mass,
  output logic              hv_pgm,
  output logic              hv_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int ROW_LSB = $clog2(ROW_BYTES);
  localparam int C_NVS   = T_NVS_US * CYC_PER_US;
  localparam int C_PGS   = T_PGS_US * CYC_PER_US;
  localparam int C_ME    = T_MERASE_US * CYC_PER_US;
  localparam int C_NVHL  = T_NVHL_US * CYC_PER_US;
  localparam int C_RCV   = T_RCV_US * CYC_PER_US;
  localparam int C_PMAX  = T_PROG_MAX_US * CYC_PER_US;
  localparam int C_MAX   = max2(max2(max2(C_NVS, C_PGS), max2(C_ME, C_NVHL)),
                                max2(C_RCV, C_PMAX));
  localparam int TW      = $clog2(C_MAX + 1);

  seq_state_t st_q, st_n;
  logic       op_q, op_n;
  logic       tm_load, tm_exp;
  logic [TW-1:0] tm_val;
  logic       rej;
  seq_err_t   rej_code;
  logic       cmd_take, rej_now, byte_take, byte_blank, row_last, finish;
  logic       abort_q, abort_set;
  seq_err_t   abort_code_q, abort_code_n;
  logic       mode_on_n;

  fhs_cmd_screen #(.ROW_LSB(ROW_LSB)) u_screen (
    .is_erase   (cmd_op),
    .row_offset (cmd_addr[ROW_LSB-1:0]),
    .protect_val(protect_val),
    .reject     (rej),
    .reject_code(rej_code)
  );

  fhs_dwell_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tm_load),
    .load_val(tm_val),
    .expired (tm_exp)
  );

  fhs_row_tracker #(.ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB)) u_row (
    .clk     (clk),
    .rst     (rst),
    .start   (cmd_take),
    .base    (cmd_addr),
    .advance (byte_take),
    .cur_addr(chk_addr),
    .at_last (row_last)
  );

  assign cmd_take   = (st_q == ST_IDLE) && cmd_valid && !rej;
  assign rej_now    = (st_q == ST_IDLE) && cmd_valid && rej;
  assign byte_take  = wr_ready && wr_valid;
  assign byte_blank = (chk_data == 8'hFF);
  assign finish     = (st_q == ST_RECOVER) && tm_exp;
  assign op_n       = (st_q == ST_IDLE) ? cmd_op : op_q;

  always_comb begin
    st_n         = st_q;
    tm_load      = 1'b0;
    tm_val       = '0;
    abort_set    = 1'b0;
    abort_code_n = abort_code_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_take) begin
          st_n    = ST_SETUP;
          tm_load = 1'b1;
          tm_val  = TW'(C_NVS - 1);
        end
      end
      ST_SETUP: begin
        if (tm_exp) begin
          tm_load = 1'b1;
          if (op_q) begin
            st_n   = ST_HV_ERASE;
            tm_val = TW'(C_ME - 1);
          end else begin
            st_n   = ST_HV_PGS;
            tm_val = TW'(C_PGS - 1);
          end
        end
      end
      ST_HV_ERASE: begin
        if (tm_exp) begin
          st_n    = ST_HOLD;
          tm_load = 1'b1;
          tm_val  = TW'(C_NVHL - 1);
        end
      end
      ST_HV_PGS: begin
        if (tm_exp) begin
          st_n    = ST_PROG;
          tm_load = 1'b1;
          tm_val  = TW'(C_PMAX - 1);
        end
      end
      ST_PROG: begin
        if (byte_take) begin
          tm_load = 1'b1;
          if (!byte_blank) begin
            st_n         = ST_HOLD;
            tm_val       = TW'(C_NVHL - 1);
            abort_set    = 1'b1;
            abort_code_n = ERR_BLANK;
          end else if (row_last) begin
            st_n   = ST_HOLD;
            tm_val = TW'(C_NVHL - 1);
          end else begin
            tm_val = TW'(C_PMAX - 1);
          end
        end else if (tm_exp) begin
          st_n         = ST_HOLD;
          tm_load      = 1'b1;
          tm_val       = TW'(C_NVHL - 1);
          abort_set    = 1'b1;
          abort_code_n = ERR_TIMEOUT;
        end
      end
      ST_HOLD: begin
        if (tm_exp) begin
          st_n    = ST_RECOVER;
          tm_load = 1'b1;
          tm_val  = TW'(C_RCV - 1);
        end
      end
      ST_RECOVER: begin
        if (tm_exp) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign mode_on_n = (st_n == ST_SETUP) || (st_n == ST_HV_ERASE) ||
                     (st_n == ST_HV_PGS) || (st_n == ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      op_q         <= 1'b0;
      abort_q      <= 1'b0;
      abort_code_q <= ERR_PROTECT;
      hv_erase     <= 1'b0;
      hv_mass      <= 1'b0;
      hv_pgm       <= 1'b0;
      hv_en        <= 1'b0;
      busy         <= 1'b0;
      wr_ready     <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      err_code     <= 2'd0;
      prog_we      <= 1'b0;
      prog_addr    <= '0;
      prog_data    <= 8'h00;
    end else begin
      st_q     <= st_n;
      op_q     <= op_n;
      hv_erase <= mode_on_n && op_n;
      hv_mass  <= mode_on_n && op_n;
      hv_pgm   <= mode_on_n && !op_n;
      hv_en    <= (st_n == ST_HV_ERASE) || (st_n == ST_HV_PGS) ||
                  (st_n == ST_PROG) || (st_n == ST_HOLD);
      busy     <= (st_n != ST_IDLE);
      wr_ready <= (st_n == ST_PROG);
      if (cmd_take) begin
        abort_q <= 1'b0;
      end else if (abort_set) begin
        abort_q      <= 1'b1;
        abort_code_q <= abort_code_n;
      end
      done     <= finish && !abort_q;
      err      <= rej_now || (finish && abort_q);
      err_code <= rej_now ? rej_code : abort_code_q;
      prog_we  <= byte_take && byte_blank;
      if (byte_take) begin
        prog_addr <= chk_addr;
        prog_data <= wr_data;
      end
    end
  end

  // R3: high voltage only drops after every mode line is already released
  a_r3_hv_drop_after_modes: assert property (@(posedge clk) disable iff (rst)
    $fell(hv_en) |-> !(hv_pgm || hv_erase || hv_mass));

  // R3: high voltage only rises on top of a mode line that was already on
  a_r3_hv_rise_after_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_en) |-> ((hv_pgm || hv_erase) && $past(hv_pgm || hv_erase)));

  // R3: no mode line is switched on under high voltage
  a_r3_mode_rise_hv_off: assert property (@(posedge clk) disable iff (rst)
    ($rose(hv_pgm) || $rose(hv_erase)) |-> !hv_en);

  // R8: bytes are only taken while programming voltage is applied
  a_r8_ready_under_hv: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (hv_pgm && hv_en));

  // R12: end pulses exclusive and done lasts a single cycle
  a_r12_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: busy ends exactly with an end pulse
  a_r4_busy_end_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || err));

  // R4: no end pulse while high voltage is still applied
  a_r4_end_after_hv: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !hv_en);

endmodule

// File: tb/test_flash_hv_sequencer.sv
module test_flash_hv_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int ROWB   = 32;
  localparam int CPU    = 2;
  localparam int NVS_C  = 10 * CPU;
  localparam int PGS_C  = 5 * CPU;
  localparam int ME_C   = 4000 * CPU;
  localparam int NVHL_C = 100 * CPU;
  localparam int RCV_C  = 1 * CPU;
  localparam int PM_C   = 30 * CPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_op = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0] protect_val = 8'hFF;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready;
  logic [ADDR_W-1:0] chk_addr;
  logic [7:0] chk_data;
  logic prog_we;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0] prog_data;
  logic hv_erase, hv_mass, hv_pgm, hv_en, busy, done, err;
  logic [1:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_hv_sequencer #(.ADDR_W(ADDR_W), .ROW_BYTES(ROWB), .CYC_PER_US(CPU)) i_flash_hv_sequencer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .protect_val(protect_val), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .chk_addr(chk_addr), .chk_data(chk_data), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .hv_erase(hv_erase), .hv_mass(hv_mass), .hv_pgm(hv_pgm),
    .hv_en(hv_en), .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  // array model
  logic [7:0] mem [256];
  logic fill_req = 1'b0;
  logic poke_en = 1'b0;
  logic [7:0] poke_addr = 8'h00;
  logic [7:0] poke_val = 8'h00;
  assign chk_data = mem[chk_addr];

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
    end else if (poke_en) begin
      mem[poke_addr] <= poke_val;
    end else if (prog_we) begin
      mem[prog_addr] <= prog_data;
    end
  end

  // monitor
  int cyc = 0;
  int t_mode_r, t_mode_f, t_hv_r, t_hv_f, t_rdy, t_acc, t_done, t_err;
  int n_mode_r = 0, n_rdy = 0, n_done = 0, n_errp = 0, n_fin = 0, n_act = 0, n_busy = 0, n_we = 0;
  int bad_order = 0;
  int busy_at_end = 0;
  logic [1:0] last_code = 2'd0;
  logic p_mode = 1'b0, p_hv = 1'b0, p_rdy = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!p_mode && (hv_pgm || hv_erase)) begin t_mode_r = cyc; n_mode_r++; if (hv_en) bad_order++; end
      if (p_mode && !(hv_pgm || hv_erase)) t_mode_f = cyc;
      if (!p_hv && hv_en) begin t_hv_r = cyc; if (!(hv_pgm || hv_erase)) bad_order++; end
      if (p_hv && !hv_en) begin t_hv_f = cyc; if (hv_pgm || hv_erase || hv_mass) bad_order++; end
      if (hv_erase != hv_mass) bad_order++;
      if (!p_rdy && wr_ready) begin t_rdy = cyc; n_rdy++; end
      if (wr_ready && wr_valid) t_acc = cyc + 1;
      if (hv_pgm || hv_erase || hv_mass || hv_en) n_act++;
      if (busy) n_busy++;
      if (prog_we) n_we++;
      if (done) begin t_done = cyc; n_done++; n_fin++; if (busy) busy_at_end++; end
      if (err) begin t_err = cyc; n_errp++; n_fin++; last_code = err_code; if (busy) busy_at_end++; end
      p_mode = hv_pgm || hv_erase;
      p_hv   = hv_en;
      p_rdy  = wr_ready;
    end
  end

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] row_data [ROWB];
  int gaps [ROWB];
  logic [7:0] exp_row [ROWB];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic op, input logic [7:0] addr);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_fin(input int snap);
    while (n_fin == snap) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      if (gaps[i] > 0) repeat (gaps[i]) @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = row_data[i];
      while (!wr_ready && busy) @(negedge clk);
      if (!wr_ready) begin
        wr_valid = 1'b0;
        break;
      end
      @(negedge clk);
      wr_valid = 1'b0;
    end
    wr_valid = 1'b0;
  endtask

  task automatic cmp_row(input int base, input string req);
    int bad = 0;
    for (int i = 0; i < ROWB; i++) if (mem[base + i] !== exp_row[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  function automatic bit gap_ok(input int a, input int b, input int want);
    return (a - b) == want;
  endfunction

  task automatic fill_random(input int gmax);
    for (int i = 0; i < ROWB; i++) begin
      row_data[i] = 8'($urandom_range(0, 255));
      gaps[i] = (gmax > 0) ? $urandom_range(0, gmax) : 0;
    end
  endtask

  // one full-row program with checks of R3, R4, R7, R8, R12
  task automatic prog_row(input int base, input int special_gap_idx);
    int snap, d0, e0;
    fill_random(3);
    if (special_gap_idx >= 0) gaps[special_gap_idx] = PM_C - 1;
    for (int i = 0; i < ROWB; i++) exp_row[i] = row_data[i];
    snap = n_fin; d0 = n_done; e0 = n_errp;
    issue(1'b0, 8'(base));
    send_bytes(ROWB);
    wait_fin(snap);
    check(gap_ok(t_hv_r, t_mode_r, NVS_C), "R7 pgm to hv", t_hv_r - t_mode_r, NVS_C);
    check(gap_ok(t_rdy, t_hv_r, PGS_C), "R7 hv to ready", t_rdy - t_hv_r, PGS_C);
    check(t_mode_f == t_acc, "R8 pgm release after last byte", t_mode_f, t_acc);
    cmp_row(base, "R8 row contents");
    check(gap_ok(t_hv_f, t_mode_f, NVHL_C), "R3 hold", t_hv_f - t_mode_f, NVHL_C);
    check(gap_ok(t_done, t_hv_f, RCV_C), "R4 recovery", t_done - t_hv_f, RCV_C);
    check((n_done - d0 == 1) && (n_errp == e0), "R12 single done no err (R10 boundary gap)",
          n_done - d0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int snap, a0, b0, m0, r0, d0, w0;
    void'($urandom(32'd4321));
    fill_req = 1'b1;
    repeat (3) @(negedge clk);
    fill_req = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(!(hv_erase || hv_mass || hv_pgm || hv_en), "R1 hv lines low", int'(hv_en), 0);
    check(!(busy || done || err || wr_ready || prog_we), "R1 status low", int'(busy), 0);

    // R5 protected erase refused
    protect_val = 8'h7F;
    snap = n_fin; a0 = n_act; b0 = n_busy;
    issue(1'b1, 8'h10);
    wait_fin(snap);
    check(last_code == 2'd0 && t_err == snap * 0 + t_err, "R5 protect code", int'(last_code), 0);
    check(n_act == a0 && n_busy == b0, "R5 no line activity", n_act - a0, 0);
    protect_val = 8'hFF;

    // R6 misaligned row refused
    snap = n_fin; a0 = n_act;
    issue(1'b0, 8'h23);
    wait_fin(snap);
    check(last_code == 2'd1, "R6 align code", int'(last_code), 1);
    check(n_act == a0, "R6 no line activity", n_act - a0, 0);

    // R2 mass erase with R11 command while busy
    snap = n_fin; m0 = n_mode_r; r0 = n_rdy; d0 = n_done;
    issue(1'b1, 8'h40);
    repeat (50) @(negedge clk);
    issue(1'b0, 8'h20);
    wait_fin(snap);
    check(gap_ok(t_hv_r, t_mode_r, NVS_C), "R2 nvs", t_hv_r - t_mode_r, NVS_C);
    check(gap_ok(t_mode_f, t_hv_r, ME_C), "R2 erase dwell", t_mode_f - t_hv_r, ME_C);
    check(gap_ok(t_hv_f, t_mode_f, NVHL_C), "R3 erase hold", t_hv_f - t_mode_f, NVHL_C);
    check(gap_ok(t_done, t_hv_f, RCV_C), "R4 erase recovery", t_done - t_hv_f, RCV_C);
    check(n_mode_r - m0 == 1 && n_rdy == r0, "R11 busy command ignored", n_mode_r - m0, 1);
    check(n_done - d0 == 1, "R12 erase done once", n_done - d0, 1);
    fill_req = 1'b1; @(negedge clk); fill_req = 1'b0;

    // random row programs, one with the longest tolerated gap (R10 boundary)
    prog_row(8'h20, -1);
    prog_row(8'h40, 10);
    prog_row(8'h60, -1);

    // R9 non-blank target aborts
    poke_addr = 8'h85; poke_val = 8'h3C; poke_en = 1'b1;
    @(negedge clk); poke_en = 1'b0;
    fill_random(2);
    for (int i = 0; i < ROWB; i++) exp_row[i] = (i < 5) ? row_data[i] : 8'hFF;
    exp_row[5] = 8'h3C;
    snap = n_fin; d0 = n_done; w0 = n_we;
    issue(1'b0, 8'h80);
    send_bytes(ROWB);
    wait_fin(snap);
    check(last_code == 2'd2, "R9 blank code", int'(last_code), 2);
    check(n_we - w0 == 5, "R9 writes before abort", n_we - w0, 5);
    cmp_row(8'h80, "R9 row contents");
    check(t_mode_f == t_acc, "R9 pgm release at abort", t_mode_f, t_acc);
    check(gap_ok(t_hv_f, t_mode_f, NVHL_C), "R3 abort hold", t_hv_f - t_mode_f, NVHL_C);
    check(n_done == d0, "R12 no done on abort", n_done - d0, 0);

    // R10 stall after four bytes
    fill_random(2);
    for (int i = 0; i < ROWB; i++) exp_row[i] = (i < 4) ? row_data[i] : 8'hFF;
    snap = n_fin;
    issue(1'b0, 8'hA0);
    send_bytes(4);
    wait_fin(snap);
    check(last_code == 2'd3, "R10 timeout code", int'(last_code), 3);
    check(gap_ok(t_mode_f, t_acc, PM_C), "R10 stall limit", t_mode_f - t_acc, PM_C);
    cmp_row(8'hA0, "R10 row contents");
    check(gap_ok(t_err, t_hv_f, RCV_C), "R4 abort recovery", t_err - t_hv_f, RCV_C);

    // R10 stall with no byte at all
    snap = n_fin;
    issue(1'b0, 8'hC0);
    wait_fin(snap);
    check(last_code == 2'd3, "R10 empty timeout code", int'(last_code), 3);
    check(gap_ok(t_mode_f, t_rdy, PM_C), "R10 empty stall limit", t_mode_f - t_rdy, PM_C);

    check(bad_order == 0, "R3 line ordering", bad_order, 0);
    check(busy_at_end == 0, "R4 busy low at end pulse", busy_at_end, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule